// File: doc/BRIEF.md
# Linked-Pool Sharer Directory

This block is a coherence directory for a set of memory blocks. It does not give each block a fixed row of sharer slots. Instead, every block owns a small header: a dirty flag and a head index. Sharer records come from one common pool. Each pool record holds a processor identifier and the index of the next record, so the sharers of a block form a singly linked chain that starts at the header. Unused records form a chain of their own, called the spare chain. An all-ones index acts as the end-of-chain marker.

A read request adds the requester to the front of the block's chain in a single cycle. A write request follows the chain one record per cycle. For every record that names a processor other than the writer, it emits an invalidation target, and it returns every record it visits to the spare chain. It then leaves a single record for the writer and sets the dirty flag. If no spare record is available for an addition, the request is refused and flagged, and every chain stays as it was.

The control is a three-state machine:
- **IDLE** accepts requests. A read completes here. IDLE→WALK is taken on an accepted write that can proceed.
- **WALK** visits one record per cycle. WALK→CLAIM is taken when the cursor reaches the end marker.
- **CLAIM** allocates the writer's record. CLAIM→IDLE is always taken.

Top module: `lps_directory`

## Requirements
- R1: After reset, every block's chain is empty, the pool has free records (`pool_empty`=0) and `req_ready`=1. The first write to any block emits no invalidation.
- R2: A read accepted while the pool has a free record raises `done` in the next cycle with `done_ovf`=0. It adds the requester to the front of the block's chain and uses up exactly one record.
- R3: A read accepted while the pool is empty raises `done` with `done_ovf`=1 in the next cycle. No chain changes, and `pool_empty` stays 1.
- R4: A write emits one `inv_valid` pulse for each record in the block's chain whose processor differs from the writer. The pulses come in chain order, most recent sharer first, and records that name the writer produce no pulse.
- R5: Every record visited by a write goes back to the pool. After the write, the number of records in use has changed by one minus the old chain length.
- R6: After a write completes, the block's chain holds exactly one record, naming the writer, and the block's dirty flag is 1.
- R7: `done_dirty` reports the block's dirty flag as it was when the request was accepted. A successful read clears the flag.
- R8: A write to a block with an empty chain while the pool is empty completes with `done_ovf`=1. It changes nothing.
- R9: `req_ready` is 0 from the cycle after a write is accepted until the cycle in which its `done` is high, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write (invalidate), 0 = read (add sharer) |
| req_blk | input | BLK_W | Memory block index |
| req_proc | input | PROC_W | Requesting processor |
| req_ready | output | 1 | Machine is idle and takes a request |
| done | output | 1 | Request completed (one cycle) |
| done_ovf | output | 1 | Completed request was refused for lack of a pool record |
| done_dirty | output | 1 | Dirty flag of the block when the request was accepted |
| inv_valid | output | 1 | An invalidation target is presented |
| inv_proc | output | PROC_W | Processor to invalidate |
| pool_empty | output | 1 | No free record remains in the pool |

## Verification
A broken chain or a broken spare chain shows up first as a wrong invalidation sequence from a later write to that block, or as `pool_empty` rising at the wrong point. A pointer that is lost or duplicated shifts the occupancy count, so exhaustion then arrives too early or too late. A header that is wrongly updated shows a stale or missing target in the next write to that block, or a wrong `done_dirty`. The bench therefore checks the whole target sequence and `pool_empty` after every operation, so such an error is caught within the first write or fill that touches the damaged state.

// File: rtl/lps_pkg.sv
package lps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_CLAIM = 2'd2
    } walk_state_e;
endpackage

// File: rtl/lps_header_array.sv
module lps_header_array #(
    parameter int BLK_W  = 3,
    parameter int LINK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  rd_blk_i,
    output logic [LINK_W-1:0] head_o,
    output logic              dirty_o,
    input  logic              wr_i,
    input  logic [LINK_W-1:0] wr_head_i,
    input  logic              wr_dirty_i
);
    localparam int NBLK = 1 << BLK_W;
    localparam logic [LINK_W-1:0] TERM = '1;

    logic [LINK_W-1:0] head_q  [NBLK];
    logic              dirty_q [NBLK];

    assign head_o  = head_q[rd_blk_i];
    assign dirty_o = dirty_q[rd_blk_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                head_q[i]  <= TERM;
                dirty_q[i] <= 1'b0;
            end
        end else if (wr_i) begin
            head_q[rd_blk_i]  <= wr_head_i;
            dirty_q[rd_blk_i] <= wr_dirty_i;
        end
    end

    AST_HDR_NO_TERM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> wr_head_i != TERM) else $error("header written with end marker"); // R2
endmodule

// File: rtl/lps_entry_pool.sv
module lps_entry_pool #(
    parameter int PROC_W = 3,
    parameter int LINK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [PROC_W-1:0] alloc_proc_i,
    input  logic [LINK_W-1:0] alloc_link_i,
    output logic [LINK_W-1:0] alloc_idx_o,
    input  logic              free_i,
    input  logic [LINK_W-1:0] free_idx_i,
    input  logic [LINK_W-1:0] rd_idx_i,
    output logic [PROC_W-1:0] rd_proc_o,
    output logic [LINK_W-1:0] rd_link_o,
    output logic              empty_o
);
    localparam int SLOTS = 1 << LINK_W;
    localparam int DEPTH = SLOTS - 1;
    localparam logic [LINK_W-1:0] TERM = '1;

    logic [PROC_W-1:0] proc_mem [SLOTS];
    logic [LINK_W-1:0] link_mem [SLOTS];
    logic [LINK_W-1:0] spare_q;

    assign alloc_idx_o = spare_q;
    assign empty_o     = (spare_q == TERM);
    assign rd_proc_o   = proc_mem[rd_idx_i];
    assign rd_link_o   = link_mem[rd_idx_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                proc_mem[i] <= '0;
                link_mem[i] <= (i + 1 < DEPTH) ? LINK_W'(i + 1) : TERM;
            end
        end else if (alloc_i) begin
            spare_q           <= link_mem[spare_q];
            proc_mem[spare_q] <= alloc_proc_i;
            link_mem[spare_q] <= alloc_link_i;
        end else if (free_i) begin
            link_mem[free_idx_i] <= spare_q;
            spare_q              <= free_idx_i;
        end
    end

    AST_POOL_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_i && free_i)) else $error("alloc and free together"); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !empty_o) else $error("alloc from empty pool"); // R3
    AST_FREE_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_i && free_idx_i != TERM) |=> !empty_o) else $error("freed record lost"); // R5
endmodule

// File: rtl/lps_directory.sv
module lps_directory #(
    parameter int BLK_W  = 3,
    parameter int PROC_W = 3,
    parameter int LINK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [PROC_W-1:0] req_proc,
    output logic              req_ready,
    output logic              done,
    output logic              done_ovf,
    output logic              done_dirty,
    output logic              inv_valid,
    output logic [PROC_W-1:0] inv_proc,
    output logic              pool_empty
);
    import lps_pkg::*;
    localparam logic [LINK_W-1:0] TERM = '1;

    walk_state_e state_q, state_d;
    logic [LINK_W-1:0] cur_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PROC_W-1:0] proc_q;
    logic              dirty_q;

    logic [BLK_W-1:0]  hdr_blk;
    logic [LINK_W-1:0] hdr_head, alloc_idx, alloc_link, rd_link;
    logic [PROC_W-1:0] alloc_proc, rd_proc;
    logic              hdr_dirty, alloc, free_en;
    logic              acc_rd, acc_wr, wr_refuse;

    assign req_ready  = (state_q == ST_IDLE);
    assign acc_rd     = req_ready && req_valid && !req_write;
    assign acc_wr     = req_ready && req_valid && req_write;
    assign hdr_blk    = req_ready ? req_blk : blk_q;
    assign wr_refuse  = (hdr_head == TERM) && pool_empty;
    assign alloc      = (acc_rd && !pool_empty) || (state_q == ST_CLAIM);
    assign alloc_proc = (state_q == ST_CLAIM) ? proc_q : req_proc;
    assign alloc_link = (state_q == ST_CLAIM) ? TERM : hdr_head;
    assign free_en    = (state_q == ST_WALK) && (cur_q != TERM);

    lps_header_array #(.BLK_W(BLK_W), .LINK_W(LINK_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .rd_blk_i(hdr_blk), .head_o(hdr_head),
        .dirty_o(hdr_dirty), .wr_i(alloc), .wr_head_i(alloc_idx),
        .wr_dirty_i(state_q == ST_CLAIM)
    );

    lps_entry_pool #(.PROC_W(PROC_W), .LINK_W(LINK_W)) u_pool (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .alloc_proc_i(alloc_proc),
        .alloc_link_i(alloc_link), .alloc_idx_o(alloc_idx), .free_i(free_en),
        .free_idx_i(cur_q), .rd_idx_i(cur_q), .rd_proc_o(rd_proc),
        .rd_link_o(rd_link), .empty_o(pool_empty)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (acc_wr && !wr_refuse) state_d = ST_WALK;
            ST_WALK:  if (cur_q == TERM) state_d = ST_CLAIM;
            ST_CLAIM: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= TERM;
            blk_q      <= '0;
            proc_q     <= '0;
            dirty_q    <= 1'b0;
            done       <= 1'b0;
            done_ovf   <= 1'b0;
            done_dirty <= 1'b0;
            inv_valid  <= 1'b0;
            inv_proc   <= '0;
        end else begin
            done      <= 1'b0;
            done_ovf  <= 1'b0;
            inv_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_rd) begin
                        done       <= 1'b1;
                        done_ovf   <= pool_empty;
                        done_dirty <= hdr_dirty;
                    end else if (acc_wr) begin
                        blk_q   <= req_blk;
                        proc_q  <= req_proc;
                        dirty_q <= hdr_dirty;
                        cur_q   <= hdr_head;
                        if (wr_refuse) begin
                            done       <= 1'b1;
                            done_ovf   <= 1'b1;
                            done_dirty <= hdr_dirty;
                        end
                    end
                end
                ST_WALK: begin
                    if (cur_q != TERM) begin
                        inv_valid <= (rd_proc != proc_q);
                        inv_proc  <= rd_proc;
                        cur_q     <= rd_link;
                    end
                end
                ST_CLAIM: begin
                    done       <= 1'b1;
                    done_dirty <= dirty_q;
                end
                default: ;
            endcase
        end
    end

    AST_INV_NOT_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_proc != proc_q) else $error("writer invalidated"); // R4
    AST_BUSY_DURING_INV: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !req_ready) else $error("ready during walk"); // R9
    AST_OVF_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done_ovf |-> (pool_empty && done)) else $error("refusal with free record"); // R3
    AST_CLAIM_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLAIM) |-> !pool_empty) else $error("no record for writer"); // R6
endmodule

// File: tb/tb_lps_directory.sv
module tb_lps_directory;
    localparam int BLK_W = 3, PROC_W = 3, LINK_W = 4;
    localparam int NBLK = 1 << BLK_W;
    localparam int DEPTH = (1 << LINK_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [BLK_W-1:0] req_blk = '0;
    logic [PROC_W-1:0] req_proc = '0;
    logic req_ready, done, done_ovf, done_dirty, inv_valid, pool_empty;
    logic [PROC_W-1:0] inv_proc;

    lps_directory #(.BLK_W(BLK_W), .PROC_W(PROC_W), .LINK_W(LINK_W)) dut (.*);

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    int mdl_list [NBLK][$];
    bit mdl_dirty [NBLK];
    int used = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_refuse(input bit wr, input int b);
        if (wr) return (mdl_list[b].size() == 0) && (used == DEPTH);
        return used == DEPTH;
    endfunction

    task automatic do_op(input bit wr, input int b, input int p);
        int exp_inv[$];
        int got_inv[$];
        bit refuse, edirty;
        int cyc;
        refuse = exp_refuse(wr, b);
        edirty = mdl_dirty[b];
        if (wr && !refuse)
            foreach (mdl_list[b][i]) if (mdl_list[b][i] != p) exp_inv.push_back(mdl_list[b][i]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 idle ready", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_blk = BLK_W'(b); req_proc = PROC_W'(p);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 64) begin
            chk(req_ready == 1'b0, "R9 busy during walk", int'(req_ready), 0);
            if (inv_valid) got_inv.push_back(int'(inv_proc));
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R2 done seen", int'(done), 1);
        if (!wr) chk(cyc == 0, "R2 read latency", cyc, 0);
        chk(done_ovf == refuse, wr ? "R8 write refusal" : "R3 read refusal", int'(done_ovf), int'(refuse));
        chk(done_dirty == edirty, "R7 prior dirty", int'(done_dirty), int'(edirty));
        chk(got_inv.size() == exp_inv.size(), "R4 invalidation count", got_inv.size(), exp_inv.size());
        foreach (exp_inv[i])
            if (i < got_inv.size())
                chk(got_inv[i] == exp_inv[i], "R4 invalidation order", got_inv[i], exp_inv[i]);
        if (!refuse) begin
            if (wr) begin
                used = used - mdl_list[b].size() + 1;
                mdl_list[b].delete();
                mdl_list[b].push_back(p);
                mdl_dirty[b] = 1'b1;
            end else begin
                used++;
                mdl_list[b].push_front(p);
                mdl_dirty[b] = 1'b0;
            end
        end
        chk(pool_empty == (used == DEPTH), "R5 pool occupancy", int'(pool_empty), int'(used == DEPTH));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pool_empty == 1'b0, "R1 reset pool", int'(pool_empty), 0);
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        chk(done == 1'b0 && inv_valid == 1'b0, "R1 reset quiet", int'(done), 0);
        do_op(1'b1, 5, 3);                       // R1 first write: no targets, R6 dirty
        do_op(1'b1, 5, 4);                       // R6 only previous writer invalidated
        do_op(1'b0, 5, 1);                       // R7 read sees dirty, clears it
        do_op(1'b0, 5, 4);                       // R4 writer's own record skipped below
        do_op(1'b0, 5, 2);
        do_op(1'b1, 5, 4);                       // R4 order 2,1 ; R5 records returned
        for (int i = 0; i < DEPTH; i++) do_op(1'b0, 0, i % 8); // R3 fill the pool
        do_op(1'b0, 2, 6);                       // R3 refused read
        do_op(1'b1, 3, 1);                       // R8 refused write on empty chain
        do_op(1'b1, 0, 0);                       // R5 full walk frees pool
        for (int n = 0; n < 600; n++) begin
            bit wr;
            wr = ($urandom % 10) < 3;
            do_op(wr, int'($urandom % NBLK), int'($urandom % 8));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule